// File: doc/BRIEF.md
# Register Hazard Scoreboard and Operand Forwarding Control

This block is the issue-control logic of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) that has a two-stage multiplier running beside the memory stage. It keeps a location record for every architectural register. The record names where the newest value of that register sits. An ALU result sits in execute and then in memory. A load sits in execute, where its data is not ready, and then in memory. A multiply passes through execute and then through multiplier stages one and two. Every value ends in the register file.

Each cycle, the block takes the decoded instruction. It looks up both source registers in the record. If every source is available, the instruction issues and the block drives one routing select per operand. Each select names the register file or a forwarding path. If a source is still being produced, the block holds decode and drives a bubble into execute. It also holds an instruction that would write back in the same cycle as an older multiply, so that one register write port is enough. A flush kills the decode instruction and returns every record to the register file.

Timing of a producer decoded in cycle t: an ALU or load sits in execute at t+1, in memory at t+2, and is in the register file from t+3. A multiply sits in execute at t+1, in multiplier stage one at t+2, in multiplier stage two at t+3, and is in the register file from t+4. The multiply writes back as it leaves stage two, which is the same cycle in which an ALU or load decoded at t+1 writes back.

Top module: `hazard_interlock`

## Requirements
- R1: Reset returns every register record to the register file. A valid instruction decoded after reset issues with stall low and both selects 0, even if a load was pending when reset arrived.
- R2: Select codes are 0 = register file, 1 = execute stage, 2 = memory stage, 3 = multiplier stage two. Class codes are 0 = ALU, 1 = load, 2 = multiply. A consumer of an ALU result decoded one, two, or three or more cycles after the producer gets select 1, 2 or 0 respectively, without stalling.
- R3: A consumer decoded in the cycle right after a load to the same register stalls for exactly one cycle. It then issues with select 2.
- R4: A consumer decoded in the cycle right after a multiply to the same register stalls for exactly two cycles. It then issues with select 3.
- R5: While stalled, stall_o and bubble_o are both 1, both selects are 0, and the held instruction leaves no record. When dec_valid_i is 0, bubble_o is 1 and stall_o is 0.
- R6: An ALU or load with a nonzero destination, decoded in the cycle right after a multiply with a nonzero destination, stalls for one cycle even when its sources are free.
- R7: Register 0 never causes a stall and always selects 0. An instruction whose destination is register 0 leaves no record. A multiply to register 0 therefore causes no write-port stall.
- R8: While flush_i is 1, the decode instruction does not issue: bubble_o is 1, stall_o is 0 and both selects are 0. In the next cycle every record is back at the register file.
- R9: When two in-flight producers target the same register, the select follows the youngest one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Pipeline flush: kills decode, clears all records |
| dec_valid_i | input | 1 | Decode holds an instruction |
| dec_cls_i | input | 2 | Instruction class (0 ALU, 1 load, 2 multiply) |
| dec_rd_i | input | IDX_W | Destination register number (0 = no write) |
| dec_rs1_i | input | IDX_W | First source register number |
| dec_rs2_i | input | IDX_W | Second source register number |
| sel_a_o | output | 2 | Routing select for the first operand |
| sel_b_o | output | 2 | Routing select for the second operand |
| stall_o | output | 1 | Hold fetch and decode this cycle |
| bubble_o | output | 1 | Execute receives a no-op this cycle |

## Verification
The properties assume that the front end holds a stalled instruction in decode unchanged. They also assume that every instruction names register 0 for a source it does not read. Without these, the one-cycle follow-up relations between a producer and its consumer would not refer to the same instruction. The stimulus keeps to both assumptions: each stalled vector is repeated until it issues, and unused sources are always register 0. Reset is entered only with dec_valid_i low, or with a pending producer whose record reset must clear.

// File: rtl/sb_pkg.sv
package sb_pkg;

    // where the newest value of a register currently sits
    typedef enum logic [2:0] {
        LOC_RF      = 3'd0,
        LOC_EX_ALU  = 3'd1,
        LOC_EX_LOAD = 3'd2,
        LOC_EX_MUL  = 3'd3,
        LOC_MEM     = 3'd4,
        LOC_MUL1    = 3'd5,
        LOC_MUL2    = 3'd6
    } loc_e;

    typedef enum logic [1:0] {
        CLS_ALU  = 2'd0,
        CLS_LOAD = 2'd1,
        CLS_MUL  = 2'd2,
        CLS_RSVD = 2'd3
    } cls_e;

    typedef enum logic [1:0] {
        SRC_RF   = 2'd0,
        SRC_EX   = 2'd1,
        SRC_MEM  = 2'd2,
        SRC_MUL2 = 2'd3
    } src_e;

    // one cycle of movement for a producer that stays in flight
    function automatic loc_e loc_advance(loc_e cur);
        case (cur)
            LOC_EX_ALU:  return LOC_MEM;
            LOC_EX_LOAD: return LOC_MEM;
            LOC_EX_MUL:  return LOC_MUL1;
            LOC_MUL1:    return LOC_MUL2;
            default:     return LOC_RF;
        endcase
    endfunction

    // record written for a freshly issued producer
    function automatic loc_e loc_on_issue(cls_e cls);
        case (cls)
            CLS_LOAD: return LOC_EX_LOAD;
            CLS_MUL:  return LOC_EX_MUL;
            default:  return LOC_EX_ALU;
        endcase
    endfunction

endpackage

// File: rtl/sb_loc_table.sv
module sb_loc_table
    import sb_pkg::*;
#(
    parameter  int NUM_REGS = 32,
    localparam int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flush_i,
    input  logic                    wr_en_i,
    input  logic [IDX_W-1:0]        wr_idx_i,
    input  loc_e                    wr_loc_i,
    output loc_e [NUM_REGS-1:0]     loc_o,
    output logic                    mul_in_ex_o
);

    typedef struct packed {
        loc_e [NUM_REGS-1:0] loc;
    } tbl_t;

    tbl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (flush_i) begin
                st_d.loc[r] = LOC_RF;
            end else if (wr_en_i && (r != 0) && (wr_idx_i == IDX_W'(r))) begin
                // a new producer overrides any older one: youngest wins
                st_d.loc[r] = wr_loc_i;
            end else begin
                st_d.loc[r] = loc_advance(st_q.loc[r]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        mul_in_ex_o = 1'b0;
        for (int r = 1; r < NUM_REGS; r++) begin
            if (st_q.loc[r] == LOC_EX_MUL) begin
                mul_in_ex_o = 1'b1;
            end
        end
    end

    assign loc_o = st_q.loc;

endmodule

// File: rtl/sb_operand_lookup.sv
module sb_operand_lookup
    import sb_pkg::*;
#(
    parameter  int NUM_REGS = 32,
    localparam int IDX_W    = $clog2(NUM_REGS)
) (
    input  loc_e [NUM_REGS-1:0] loc_i,
    input  logic [IDX_W-1:0]    idx_i,
    output src_e                sel_o,
    output logic                hazard_o
);

    loc_e cur;

    always_comb begin
        cur = (idx_i == '0) ? LOC_RF : loc_i[idx_i];
        sel_o    = SRC_RF;
        hazard_o = 1'b0;
        case (cur)
            LOC_EX_ALU:  sel_o = SRC_EX;
            LOC_MEM:     sel_o = SRC_MEM;
            LOC_MUL2:    sel_o = SRC_MUL2;
            LOC_EX_LOAD,
            LOC_EX_MUL,
            LOC_MUL1:    hazard_o = 1'b1;
            default:     sel_o = SRC_RF;
        endcase
    end

endmodule

// File: rtl/hazard_interlock.sv
module hazard_interlock
    import sb_pkg::*;
#(
    parameter  int NUM_REGS = 32,
    localparam int IDX_W    = $clog2(NUM_REGS),
    localparam int NUM_OPS  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             dec_valid_i,
    input  logic [1:0]       dec_cls_i,
    input  logic [IDX_W-1:0] dec_rd_i,
    input  logic [IDX_W-1:0] dec_rs1_i,
    input  logic [IDX_W-1:0] dec_rs2_i,
    output logic [1:0]       sel_a_o,
    output logic [1:0]       sel_b_o,
    output logic             stall_o,
    output logic             bubble_o
);

    loc_e [NUM_REGS-1:0]           loc;
    logic                          mul_in_ex;
    logic [NUM_OPS-1:0][IDX_W-1:0] src_idx;
    src_e [NUM_OPS-1:0]            op_sel;
    logic [NUM_OPS-1:0]            op_haz;
    cls_e                          cls;
    logic                          port_clash;
    logic                          issue;
    logic                          tbl_wr;

    assign src_idx[0] = dec_rs1_i;
    assign src_idx[1] = dec_rs2_i;
    assign cls        = cls_e'(dec_cls_i);

    sb_loc_table #(.NUM_REGS(NUM_REGS)) u_table (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush_i     (flush_i),
        .wr_en_i     (tbl_wr),
        .wr_idx_i    (dec_rd_i),
        .wr_loc_i    (loc_on_issue(cls)),
        .loc_o       (loc),
        .mul_in_ex_o (mul_in_ex)
    );

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
        sb_operand_lookup #(.NUM_REGS(NUM_REGS)) u_lookup (
            .loc_i    (loc),
            .idx_i    (src_idx[g]),
            .sel_o    (op_sel[g]),
            .hazard_o (op_haz[g])
        );
    end

    always_comb begin
        // a writer decoded behind a multiply would share its writeback cycle
        port_clash = mul_in_ex && (cls != CLS_MUL) && (dec_rd_i != '0);
        stall_o    = dec_valid_i && !flush_i && ((|op_haz) || port_clash);
        issue      = dec_valid_i && !flush_i && !stall_o;
        bubble_o   = !issue;
        tbl_wr     = issue && (dec_rd_i != '0);
        sel_a_o    = issue ? op_sel[0] : SRC_RF;
        sel_b_o    = issue ? op_sel[1] : SRC_RF;
    end

endmodule

// File: rtl/hazard_interlock_checker.sv
module hazard_interlock_checker #(
    parameter int IDX_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush_i,
    input logic             dec_valid_i,
    input logic [1:0]       dec_cls_i,
    input logic [IDX_W-1:0] dec_rd_i,
    input logic [IDX_W-1:0] dec_rs1_i,
    input logic [IDX_W-1:0] dec_rs2_i,
    input logic [1:0]       sel_a_o,
    input logic [1:0]       sel_b_o,
    input logic             stall_o,
    input logic             bubble_o
);

    logic issued;
    assign issued = dec_valid_i && !flush_i && !stall_o;

    assert_stall_bubble_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |-> bubble_o);

    assert_idle_bubble_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid_i |-> (bubble_o && !stall_o));

    assert_flush_kill_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |-> (bubble_o && !stall_o && sel_a_o == 2'd0 && sel_b_o == 2'd0));

    assert_flush_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(flush_i) |-> !stall_o);

    assert_zero_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (issued && dec_rs1_i == '0) |-> sel_a_o == 2'd0);

    assert_load_use_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(issued && dec_cls_i == 2'd1 && dec_rd_i != '0)
         && dec_valid_i && !flush_i
         && (dec_rs1_i == $past(dec_rd_i) || dec_rs2_i == $past(dec_rd_i)))
        |-> stall_o);

    assert_mul_use_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(issued && dec_cls_i == 2'd2 && dec_rd_i != '0)
         && dec_valid_i && !flush_i
         && (dec_rs1_i == $past(dec_rd_i) || dec_rs2_i == $past(dec_rd_i)))
        |-> stall_o);

    assert_port_clash_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(issued && dec_cls_i == 2'd2 && dec_rd_i != '0)
         && dec_valid_i && !flush_i && dec_cls_i != 2'd2 && dec_rd_i != '0)
        |-> stall_o);

    assert_alu_fwd_ex_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(issued && dec_cls_i == 2'd0 && dec_rd_i != '0)
         && issued && dec_rs1_i == $past(dec_rd_i))
        |-> sel_a_o == 2'd1);

endmodule

bind hazard_interlock hazard_interlock_checker #(.IDX_W(IDX_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush_i     (flush_i),
    .dec_valid_i (dec_valid_i),
    .dec_cls_i   (dec_cls_i),
    .dec_rd_i    (dec_rd_i),
    .dec_rs1_i   (dec_rs1_i),
    .dec_rs2_i   (dec_rs2_i),
    .sel_a_o     (sel_a_o),
    .sel_b_o     (sel_b_o),
    .stall_o     (stall_o),
    .bubble_o    (bubble_o)
);

// File: tb/test_hazard_interlock.sv
module test_hazard_interlock;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       flush_i = 1'b0;
    logic       dec_valid_i = 1'b0;
    logic [1:0] dec_cls_i = 2'd0;
    logic [4:0] dec_rd_i = 5'd0;
    logic [4:0] dec_rs1_i = 5'd0;
    logic [4:0] dec_rs2_i = 5'd0;
    logic [1:0] sel_a_o, sel_b_o;
    logic       stall_o, bubble_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    hazard_interlock i_hazard_interlock (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .dec_valid_i(dec_valid_i),
        .dec_cls_i(dec_cls_i), .dec_rd_i(dec_rd_i), .dec_rs1_i(dec_rs1_i),
        .dec_rs2_i(dec_rs2_i), .sel_a_o(sel_a_o), .sel_b_o(sel_b_o),
        .stall_o(stall_o), .bubble_o(bubble_o)
    );

    typedef struct packed {
        logic       fl;
        logic       vd;
        logic [1:0] cl;
        logic [4:0] rd;
        logic [4:0] r1;
        logic [4:0] r2;
        logic       st;
        logic       bb;
        logic [1:0] sa;
        logic [1:0] sb;
        logic [3:0] rq;
    } vec_t;

    localparam int NV = 37;
    // fl vd cls rd rs1 rs2 | stall bubble selA selB | requirement
    localparam vec_t VT [NV] = '{
        '{1'b0,1'b1,2'd0,5'd1, 5'd8, 5'd9, 1'b0,1'b0,2'd0,2'd0,4'd2},  // R2 producer
        '{1'b0,1'b1,2'd0,5'd2, 5'd1, 5'd7, 1'b0,1'b0,2'd1,2'd0,4'd2},  // R2 from EX
        '{1'b0,1'b1,2'd0,5'd3, 5'd1, 5'd2, 1'b0,1'b0,2'd2,2'd1,4'd2},  // R2 MEM + EX
        '{1'b0,1'b1,2'd0,5'd4, 5'd1, 5'd2, 1'b0,1'b0,2'd0,2'd2,4'd2},  // R2 RF + MEM
        '{1'b0,1'b1,2'd1,5'd5, 5'd9, 5'd0, 1'b0,1'b0,2'd0,2'd0,4'd3},  // R3 load
        '{1'b0,1'b1,2'd0,5'd6, 5'd5, 5'd4, 1'b1,1'b1,2'd0,2'd0,4'd3},  // R3 one stall
        '{1'b0,1'b1,2'd0,5'd6, 5'd5, 5'd4, 1'b0,1'b0,2'd2,2'd0,4'd3},  // R3 from MEM
        '{1'b0,1'b1,2'd2,5'd7, 5'd6, 5'd6, 1'b0,1'b0,2'd1,2'd1,4'd4},  // R4 mul
        '{1'b0,1'b1,2'd0,5'd8, 5'd7, 5'd0, 1'b1,1'b1,2'd0,2'd0,4'd4},  // R4 stall 1
        '{1'b0,1'b1,2'd0,5'd8, 5'd7, 5'd0, 1'b1,1'b1,2'd0,2'd0,4'd4},  // R4 stall 2
        '{1'b0,1'b1,2'd0,5'd8, 5'd7, 5'd0, 1'b0,1'b0,2'd3,2'd0,4'd4},  // R4 from MUL2
        '{1'b0,1'b1,2'd2,5'd9, 5'd1, 5'd2, 1'b0,1'b0,2'd0,2'd0,4'd6},  // R6 mul
        '{1'b0,1'b1,2'd0,5'd10,5'd3, 5'd4, 1'b1,1'b1,2'd0,2'd0,4'd6},  // R6 clash
        '{1'b0,1'b1,2'd0,5'd10,5'd3, 5'd4, 1'b0,1'b0,2'd0,2'd0,4'd6},  // R6 issues
        '{1'b0,1'b1,2'd1,5'd0, 5'd0, 5'd0, 1'b0,1'b0,2'd0,2'd0,4'd7},  // R7 load to r0
        '{1'b0,1'b1,2'd0,5'd11,5'd0, 5'd0, 1'b0,1'b0,2'd0,2'd0,4'd7},  // R7 no stall
        '{1'b0,1'b1,2'd2,5'd0, 5'd11,5'd0, 1'b0,1'b0,2'd1,2'd0,4'd7},  // R7 mul to r0
        '{1'b0,1'b1,2'd0,5'd12,5'd0, 5'd0, 1'b0,1'b0,2'd0,2'd0,4'd7},  // R7 no clash
        '{1'b0,1'b1,2'd0,5'd13,5'd0, 5'd0, 1'b0,1'b0,2'd0,2'd0,4'd9},  // R9 older r13
        '{1'b0,1'b1,2'd0,5'd13,5'd13,5'd12,1'b0,1'b0,2'd1,2'd2,4'd9},  // R9 younger r13
        '{1'b0,1'b1,2'd0,5'd14,5'd13,5'd0, 1'b0,1'b0,2'd1,2'd0,4'd9},  // R9 youngest wins
        '{1'b0,1'b1,2'd1,5'd15,5'd0, 5'd0, 1'b0,1'b0,2'd0,2'd0,4'd3},  // R3 load
        '{1'b0,1'b1,2'd2,5'd16,5'd14,5'd15,1'b1,1'b1,2'd0,2'd0,4'd3},  // R3 mul waits
        '{1'b0,1'b1,2'd2,5'd16,5'd14,5'd15,1'b0,1'b0,2'd0,2'd2,4'd3},  // R3 issues
        '{1'b0,1'b1,2'd2,5'd17,5'd16,5'd0, 1'b1,1'b1,2'd0,2'd0,4'd4},  // R4 mul->mul
        '{1'b0,1'b1,2'd2,5'd17,5'd16,5'd0, 1'b1,1'b1,2'd0,2'd0,4'd4},  // R4
        '{1'b0,1'b1,2'd2,5'd17,5'd16,5'd0, 1'b0,1'b0,2'd3,2'd0,4'd4},  // R4
        '{1'b0,1'b0,2'd0,5'd18,5'd17,5'd0, 1'b0,1'b1,2'd0,2'd0,4'd5},  // R5 idle
        '{1'b0,1'b1,2'd0,5'd18,5'd17,5'd0, 1'b1,1'b1,2'd0,2'd0,4'd5},  // R5 stall
        '{1'b0,1'b1,2'd0,5'd18,5'd17,5'd0, 1'b0,1'b0,2'd3,2'd0,4'd4},  // R4
        '{1'b0,1'b1,2'd1,5'd20,5'd0, 5'd0, 1'b0,1'b0,2'd0,2'd0,4'd8},  // R8 load
        '{1'b1,1'b1,2'd0,5'd21,5'd20,5'd18,1'b0,1'b1,2'd0,2'd0,4'd8},  // R8 flush
        '{1'b0,1'b1,2'd0,5'd21,5'd20,5'd18,1'b0,1'b0,2'd0,2'd0,4'd8},  // R8 cleared
        '{1'b0,1'b1,2'd0,5'd22,5'd21,5'd0, 1'b0,1'b0,2'd1,2'd0,4'd8},  // R8 reissued
        '{1'b0,1'b1,2'd2,5'd23,5'd22,5'd21,1'b0,1'b0,2'd1,2'd2,4'd6},  // R6 mul
        '{1'b0,1'b1,2'd1,5'd24,5'd0, 5'd0, 1'b1,1'b1,2'd0,2'd0,4'd6},  // R6 load clash
        '{1'b0,1'b1,2'd1,5'd24,5'd0, 5'd0, 1'b0,1'b0,2'd0,2'd0,4'd6}   // R6 issues
    };

    function automatic string req_name(logic [3:0] n);
        case (n)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            4'd8: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drive(logic fl, logic vd, logic [1:0] cl, logic [4:0] rd,
                         logic [4:0] r1, logic [4:0] r2);
        flush_i = fl; dec_valid_i = vd; dec_cls_i = cl;
        dec_rd_i = rd; dec_rs1_i = r1; dec_rs2_i = r2;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 5000 && !done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected under 5000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: state straight after reset
        drive(1'b0, 1'b1, 2'd0, 5'd0, 5'd1, 5'd2);
        #3;
        check("R1", "stall after reset", int'(stall_o), 0);
        check("R1", "selA after reset", int'(sel_a_o), 0);
        check("R1", "selB after reset", int'(sel_b_o), 0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VT[i].fl, VT[i].vd, VT[i].cl, VT[i].rd, VT[i].r1, VT[i].r2);
            #3;
            check(req_name(VT[i].rq), $sformatf("stall v%0d", i), int'(stall_o), int'(VT[i].st));
            check(req_name(VT[i].rq), $sformatf("bubble v%0d", i), int'(bubble_o), int'(VT[i].bb));
            check(req_name(VT[i].rq), $sformatf("selA v%0d", i), int'(sel_a_o), int'(VT[i].sa));
            check(req_name(VT[i].rq), $sformatf("selB v%0d", i), int'(sel_b_o), int'(VT[i].sb));
        end

        // R1: reset in the middle clears a pending load record
        @(negedge clk);
        drive(1'b0, 1'b1, 2'd1, 5'd5, 5'd0, 5'd0);
        @(negedge clk);
        rst_n = 1'b0;
        drive(1'b0, 1'b0, 2'd0, 5'd0, 5'd0, 5'd0);
        @(negedge clk);
        rst_n = 1'b1;
        drive(1'b0, 1'b1, 2'd0, 5'd6, 5'd5, 5'd0);
        #3;
        check("R1", "stall after mid reset", int'(stall_o), 0);
        check("R1", "selA after mid reset", int'(sel_a_o), 0);
        check("R1", "bubble after mid reset", int'(bubble_o), 0);

        // R3: the same load-use pair without reset stalls exactly once
        @(negedge clk);
        drive(1'b0, 1'b1, 2'd1, 5'd5, 5'd0, 5'd0);
        @(negedge clk);
        drive(1'b0, 1'b1, 2'd0, 5'd6, 5'd0, 5'd5);
        #3;
        check("R3", "stall load-use on rs2", int'(stall_o), 1);
        @(negedge clk);
        #3;
        check("R3", "stall released", int'(stall_o), 0);
        check("R3", "selB from MEM", int'(sel_b_o), 2);

        @(negedge clk);
        drive(1'b0, 1'b0, 2'd0, 5'd0, 5'd0, 5'd0);
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule